// File: doc/BRIEF.md
# Uncorrectable Error Status With Header Log

This block holds a vector of uncorrectable-error status bits together with a small FIFO of recorded error headers. An error source reports an event as a status bit index plus a 128-bit header word. The event always sets its status bit. When the log has room, the header and index are queued as well. The index of the oldest queued entry acts as the first-error pointer, and that entry's header is shown on a read-only output.

Software uses a simple register port to read the status, control and pointer words and to write them. Clearing works in one of two ways, selected by a multiple-header-recording enable. With the enable low, every status bit is plain write-one-to-clear and the log holds at most one entry. With the enable high and the log non-empty, only the bit named by the pointer reacts to a write of one. Such a write pops the oldest header, so the pointer and head header move to the next entry. The written bit stays set only if a remaining entry still refers to it.

There are two reset inputs. A cold reset clears everything. A warm reset empties the log and drops the enable, but keeps the status bits and the overflow flag.

Top module: `uerr_status_log`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the following are all zero: `err_status`, `first_ptr`, `head_hdr`, the enable, the overflow flag and the log count.
- R2: A cycle with `warm_rst` high empties the log and clears the enable. `err_status` and the overflow flag keep their values.
- R3: An error event sets `err_status[err_idx]` on the next cycle. If the event is logged into an empty log, `first_ptr` becomes `err_idx` and `head_hdr` becomes `err_hdr`.
- R4: With the enable low, a write to the status word (address 0) clears every status bit written as one. When that write has a one at the bit named by `first_ptr`, the single log entry is released.
- R5: With the enable high and the log non-empty, a status write leaves every bit except the one named by `first_ptr` unchanged. With the enable high and the log empty, a status write clears bits as in R4.
- R6: With the enable high and the log non-empty, writing one to the pointed bit pops the oldest entry. `first_ptr` and `head_hdr` then show the next entry. The pointed bit stays set exactly when a remaining entry carries the same index.
- R7: The log holds at most 4 entries with the enable high and 1 entry with it low. An event arriving when the log is full (after any pop in the same cycle) still sets its status bit. It also sets the sticky overflow flag and leaves the log unchanged.
- R8: When the log is empty, `first_ptr` is 0 and `head_hdr` is all zeros.
- R9: `rd_data` presents, one cycle after `rd_addr`, one of four words:
  - address 0: the status word;
  - address 1: the control word, with bit 0 = enable, bit 1 = overflow and bits 10:8 = log count;
  - address 2: the pointer in bits 4:0;
  - address 3: zero.
  A write to address 1 loads the enable from bit 0 and clears the overflow flag when bit 1 is one.
- R10: When an event and a status write that clears the same bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Cold reset, synchronous, active high; clears all state |
| warm_rst | input | 1 | Warm reset, synchronous, active high; clears log and enable only |
| err_valid | input | 1 | Error event strobe |
| err_idx | input | 5 | Status bit index of the event |
| err_hdr | input | 128 | Header word of the event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| err_status | output | 32 | Status bit vector |
| first_ptr | output | 5 | Index of the oldest logged error, 0 when empty |
| head_hdr | output | 128 | Header of the oldest logged error, 0 when empty |

## Verification
The bench drives the pop path with a queue that holds two entries for the same index. A design that clears the pointed bit on every pop would lose that bit early, and one that never restores it would keep a stale bit. It writes ones to non-pointed bits while recording is on, which catches a design that applies plain clearing in that mode. It fills the log to capacity in both modes, which exposes a wrong capacity or a full log that swallows the status bit or misses the overflow flag. It also checks that a warm reset keeps status while emptying the log, and that a same-cycle set and clear leaves the bit set.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_PTR    = 2'd2,
    REG_RSVD   = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_OVF_BIT = 1;
  localparam int CTRL_CNT_LSB = 8;
endpackage

// File: rtl/uerr_hdr_log.sv
module uerr_hdr_log #(
  parameter int DEPTH    = 4,
  parameter int NUM_BITS = 32,
  parameter int HDR_W    = 128,
  localparam int IDX_W   = $clog2(NUM_BITS),
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                push,
  input  logic [IDX_W-1:0]    push_idx,
  input  logic [HDR_W-1:0]    push_hdr,
  input  logic                pop,
  output logic [CNT_W-1:0]    count,
  output logic [IDX_W-1:0]    head_idx,
  output logic [HDR_W-1:0]    head_hdr,
  output logic [NUM_BITS-1:0] tail_ref
);
  // storage has no reset so it can map onto RAM
  logic [IDX_W-1:0] idx_mem [DEPTH];
  logic [HDR_W-1:0] hdr_mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      idx_mem[wr_ptr] <= push_idx;
      hdr_mem[wr_ptr] <= push_hdr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_idx = (count != '0) ? idx_mem[rd_ptr] : '0;
  assign head_hdr = (count != '0) ? hdr_mem[rd_ptr] : '0;

  // indices still referenced by entries behind the head
  always_comb begin
    tail_ref = '0;
    for (int k = 1; k < DEPTH; k++) begin
      int pos;
      pos = int'(rd_ptr) + k;
      if (pos >= DEPTH) pos = pos - DEPTH;
      if (CNT_W'(k) < count) tail_ref[idx_mem[PTR_W'(pos)]] = 1'b1;
    end
  end

  a_r7_no_overrun: assert property (@(posedge clk) disable iff (rst || flush)
    push |-> ((count != CNT_W'(DEPTH)) || pop));

  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (rst || flush)
    pop |-> (count != '0));
endmodule

// File: rtl/uerr_status_bits.sv
module uerr_status_bits #(
  parameter int NUM_BITS = 32,
  localparam int IDX_W   = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stat,
  input  logic [NUM_BITS-1:0] wr_data,
  input  logic                mhr_en,
  input  logic                log_busy,
  input  logic [IDX_W-1:0]    ptr,
  input  logic [NUM_BITS-1:0] tail_ref,
  input  logic                err_valid,
  input  logic [IDX_W-1:0]    err_idx,
  output logic [NUM_BITS-1:0] status,
  output logic                pop
);
  logic [NUM_BITS-1:0] status_nxt;

  always_comb begin
    status_nxt = status;
    pop        = 1'b0;
    if (wr_stat) begin
      if (mhr_en && log_busy) begin
        if (wr_data[ptr]) begin
          pop             = 1'b1;
          status_nxt[ptr] = tail_ref[ptr];
        end
      end else begin
        status_nxt = status & ~wr_data;
        pop        = log_busy && wr_data[ptr];
      end
    end
    if (err_valid) status_nxt[err_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_nxt;
  end

  a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> status[$past(err_idx)]);

  a_r5_others_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && mhr_en && log_busy && !err_valid) |=>
      (((status ^ $past(status)) & ~(NUM_BITS'(1) << $past(ptr))) == '0));

  a_r4_plain_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !(mhr_en && log_busy) && !err_valid) |=>
      ((status & $past(wr_data)) == '0));
endmodule

// File: rtl/uerr_status_log.sv
module uerr_status_log
  import uerr_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int NUM_BITS = 32,
  parameter int HDR_W    = 128,
  localparam int IDX_W   = $clog2(NUM_BITS),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                warm_rst,
  input  logic                err_valid,
  input  logic [IDX_W-1:0]    err_idx,
  input  logic [HDR_W-1:0]    err_hdr,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [NUM_BITS-1:0] wr_data,
  input  logic [1:0]          rd_addr,
  output logic [NUM_BITS-1:0] rd_data,
  output logic [NUM_BITS-1:0] err_status,
  output logic [IDX_W-1:0]    first_ptr,
  output logic [HDR_W-1:0]    head_hdr
);
  logic                mhr_en, ovf;
  logic [CNT_W-1:0]    count, cnt_after;
  logic [NUM_BITS-1:0] tail_ref;
  logic                pop, push, cap_hit;
  logic                wr_stat, wr_ctrl;

  assign wr_stat = wr_en && (wr_addr == REG_STATUS);
  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);

  uerr_status_bits #(.NUM_BITS(NUM_BITS)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .wr_stat   (wr_stat),
    .wr_data   (wr_data),
    .mhr_en    (mhr_en),
    .log_busy  (count != '0),
    .ptr       (first_ptr),
    .tail_ref  (tail_ref),
    .err_valid (err_valid),
    .err_idx   (err_idx),
    .status    (err_status),
    .pop       (pop)
  );

  // capacity is checked against the count left after this cycle's pop
  assign cnt_after = count - CNT_W'(pop);
  assign cap_hit   = cnt_after >= (mhr_en ? CNT_W'(DEPTH) : CNT_W'(1));
  assign push      = err_valid && !cap_hit && !warm_rst;

  uerr_hdr_log #(.DEPTH(DEPTH), .NUM_BITS(NUM_BITS), .HDR_W(HDR_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .flush    (warm_rst),
    .push     (push),
    .push_idx (err_idx),
    .push_hdr (err_hdr),
    .pop      (pop && !warm_rst),
    .count    (count),
    .head_idx (first_ptr),
    .head_hdr (head_hdr),
    .tail_ref (tail_ref)
  );

  always_ff @(posedge clk) begin
    if (rst || warm_rst)  mhr_en <= 1'b0;
    else if (wr_ctrl)     mhr_en <= wr_data[CTRL_EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else     ovf <= (ovf && !(wr_ctrl && wr_data[CTRL_OVF_BIT])) || (err_valid && cap_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      unique case (reg_addr_e'(rd_addr))
        REG_STATUS: rd_data <= err_status;
        REG_CTRL: begin
          rd_data[CTRL_EN_BIT]              <= mhr_en;
          rd_data[CTRL_OVF_BIT]             <= ovf;
          rd_data[CTRL_CNT_LSB +: CNT_W]    <= count;
        end
        REG_PTR:  rd_data[IDX_W-1:0] <= first_ptr;
        REG_RSVD: rd_data <= '0;
      endcase
    end
  end

  a_r2_warm_sticky: assert property (@(posedge clk) disable iff (rst)
    (warm_rst && !err_valid && !wr_en) |=> ($stable(err_status) && $stable(ovf) && count == '0));

  a_r7_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    (err_valid && cap_hit) |=> (ovf && count == $past(cnt_after)));

  a_r4_single_entry: assert property (@(posedge clk) disable iff (rst)
    (!mhr_en && count <= CNT_W'(1)) |=> (count <= CNT_W'(1)));
endmodule

// File: tb/test_uerr_status_log.sv
`timescale 1ns/1ps
module test_uerr_status_log;
  logic         clk = 1'b0;
  logic         rst, warm_rst, err_valid, wr_en;
  logic [4:0]   err_idx;
  logic [127:0] err_hdr;
  logic [1:0]   wr_addr, rd_addr;
  logic [31:0]  wr_data, rd_data, err_status;
  logic [4:0]   first_ptr;
  logic [127:0] head_hdr;

  always #10 clk = ~clk;

  uerr_status_log i_uerr_status_log (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .err_valid(err_valid),
    .err_idx(err_idx), .err_hdr(err_hdr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .err_status(err_status), .first_ptr(first_ptr), .head_hdr(head_hdr)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model: queue kept shifted, entry 0 is the oldest
  logic [31:0]  m_st;
  logic         m_ovf, m_mhr;
  int           m_cnt;
  logic [4:0]   q_idx [4];
  logic [127:0] q_hdr [4];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_ptr();
    return (m_cnt > 0) ? q_idx[0] : 5'd0;
  endfunction

  function automatic logic [127:0] exp_hdr();
    return (m_cnt > 0) ? q_hdr[0] : 128'd0;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return (32'(m_cnt) << 8) | (32'(m_ovf) << 1) | 32'(m_mhr);
  endfunction

  task automatic model(input bit ev, input logic [4:0] idx, input logic [127:0] hdr,
                       input bit we, input logic [1:0] wa, input logic [31:0] wd);
    logic [31:0] ns;
    bit pop, keep, novf, nmhr;
    ns = m_st; pop = 0; novf = m_ovf; nmhr = m_mhr;
    if (we && wa == 2'd0) begin
      if (m_mhr && m_cnt > 0) begin
        if (wd[q_idx[0]]) begin
          pop = 1; keep = 0;
          for (int k = 1; k < m_cnt; k++) if (q_idx[k] == q_idx[0]) keep = 1;
          ns[q_idx[0]] = keep;
        end
      end else begin
        ns = m_st & ~wd;
        if (m_cnt > 0 && wd[q_idx[0]]) pop = 1;
      end
    end
    if (we && wa == 2'd1) begin
      nmhr = wd[0];
      if (wd[1]) novf = 0;
    end
    if (pop) begin
      for (int k = 0; k < 3; k++) begin q_idx[k] = q_idx[k+1]; q_hdr[k] = q_hdr[k+1]; end
      m_cnt--;
    end
    if (ev) begin
      ns[idx] = 1'b1;
      if (m_cnt < (m_mhr ? 4 : 1)) begin
        q_idx[m_cnt] = idx; q_hdr[m_cnt] = hdr; m_cnt++;
      end else novf = 1;
    end
    m_st = ns; m_ovf = novf; m_mhr = nmhr;
  endtask

  task automatic idle_inputs();
    err_valid = 0; err_idx = '0; err_hdr = '0;
    wr_en = 0; wr_addr = '0; wr_data = '0; warm_rst = 0;
  endtask

  task automatic step(input bit ev, input logic [4:0] idx, input logic [127:0] hdr,
                      input bit we, input logic [1:0] wa, input logic [31:0] wd);
    err_valid = ev; err_idx = idx; err_hdr = hdr;
    wr_en = we; wr_addr = wa; wr_data = wd;
    model(ev, idx, hdr, we, wa, wd);
    @(posedge clk); @(negedge clk);
    idle_inputs();
  endtask

  task automatic event_in(input logic [4:0] idx, input logic [127:0] hdr);
    step(1, idx, hdr, 0, 2'd0, 32'd0);
  endtask

  task automatic reg_write(input logic [1:0] wa, input logic [31:0] wd);
    step(0, 5'd0, 128'd0, 1, wa, wd);
  endtask

  task automatic check_ports(input string req);
    check(req, 128'(err_status), 128'(m_st));
    check(req, 128'(first_ptr), 128'(exp_ptr()));
    check(req, head_hdr, exp_hdr());
  endtask

  task automatic check_read(input string req, input logic [1:0] a, input logic [31:0] exp);
    rd_addr = a;
    step(0, 5'd0, 128'd0, 0, 2'd0, 32'd0);
    check(req, 128'(rd_data), 128'(exp));
  endtask

  task automatic do_warm();
    warm_rst = 1;
    m_cnt = 0; m_mhr = 0;
    @(posedge clk); @(negedge clk);
    warm_rst = 0;
  endtask

  task automatic do_cold();
    rst = 1;
    m_st = '0; m_ovf = 0; m_mhr = 0; m_cnt = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] h1, h2, h3;
    void'($urandom(32'd2024));
    idle_inputs(); rd_addr = 2'd0; rst = 1;
    do_cold();

    // R1 / R8: reset state
    check_ports("R1");
    check("R8", 128'(first_ptr), 128'd0);
    check("R8", head_hdr, 128'd0);
    check_read("R1", 2'd1, 32'd0);

    // R3 / R4 / R7: recording disabled, capacity one
    h1 = {4{32'hA5A5_0001}};
    event_in(5'd3, h1);
    check("R3", 128'(first_ptr), 128'd3);
    check("R3", head_hdr, h1);
    event_in(5'd7, {4{32'h0000_0777}});
    check("R7", 128'(err_status), 128'h88);
    check("R7", 128'(first_ptr), 128'd3);
    check_read("R9", 2'd1, 32'h102);
    reg_write(2'd0, 32'h80);
    check("R4", 128'(err_status), 128'h08);
    check("R4", 128'(first_ptr), 128'd3);
    reg_write(2'd0, 32'h08);
    check("R4", 128'(err_status), 128'h0);
    check("R8", 128'(first_ptr), 128'd0);
    check("R8", head_hdr, 128'd0);
    reg_write(2'd1, 32'h2);
    check_read("R9", 2'd1, 32'h0);

    // R5 / R6: recording enabled, repeated index in queue
    reg_write(2'd1, 32'h1);
    h1 = {4{32'h1111_0005}}; h2 = {4{32'h2222_0009}}; h3 = {4{32'h3333_0005}};
    event_in(5'd5, h1); event_in(5'd9, h2); event_in(5'd5, h3);
    check_ports("R3");
    reg_write(2'd0, 32'h200);
    check("R5", 128'(err_status), 128'h220);
    check("R5", 128'(first_ptr), 128'd5);
    reg_write(2'd0, 32'h20);
    check("R6", 128'(err_status), 128'h220);
    check("R6", 128'(first_ptr), 128'd9);
    check("R6", head_hdr, h2);
    reg_write(2'd0, 32'h200);
    check("R6", 128'(err_status), 128'h020);
    check("R6", 128'(first_ptr), 128'd5);
    check("R6", head_hdr, h3);
    check_read("R9", 2'd2, 32'd5);
    reg_write(2'd0, 32'h20);
    check("R6", 128'(err_status), 128'h0);
    check("R8", head_hdr, 128'd0);

    // R7: fill to four, then overflow
    for (int i = 1; i <= 4; i++) event_in(5'(i), 128'(i * 3));
    event_in(5'd6, 128'hDEAD);
    check("R7", 128'(err_status), 128'h5E);
    check_read("R7", 2'd1, 32'h403);
    check("R7", 128'(first_ptr), 128'd1);

    // R2: warm reset keeps status and overflow
    do_warm();
    check("R2", 128'(err_status), 128'h5E);
    check("R2", 128'(first_ptr), 128'd0);
    check_read("R2", 2'd1, 32'h002);
    check_read("R9", 2'd0, 32'h5E);
    check_read("R9", 2'd3, 32'h0);

    // R10: same-cycle set and clear
    step(1, 5'd1, 128'h77, 1, 2'd0, 32'h2);
    check("R10", 128'(err_status[1]), 128'd1);
    check_ports("R10");

    // random phase
    reg_write(2'd1, 32'h3);
    for (int n = 0; n < 600; n++) begin
      bit ev, we;
      logic [1:0] wa;
      logic [31:0] wd;
      int r;
      ev = ($urandom % 8) < 3;
      r = $urandom % 10;
      we = r < 4; wa = 2'd0; wd = '0;
      if (r < 3) wd = ($urandom % 2) ? (32'h1 << exp_ptr()) : (32'h1 << ($urandom % 6));
      else if (r == 3) begin
        wa = 2'd1;
        wd = {30'd0, 1'($urandom % 2), 1'(($urandom % 4) != 0)};
      end
      if ((n % 97) == 96) do_warm();
      else step(ev, 5'($urandom % 6), {$urandom, $urandom, $urandom, $urandom}, we, wa, wd);
      check_ports("R6");
      if ((n % 50) == 0) check_read("R9", 2'd1, exp_ctrl());
    end

    // R1: cold reset clears sticky state
    do_cold();
    check_ports("R1");
    check_read("R1", 2'd1, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule